// File: doc/BRIEF.md
# USB Outgoing Packet Assembler with CRC16

This block builds the bytes of outgoing packets on the device side of a USB serial interface engine. A controller asks for one packet at a time by giving a packet kind. For one of the four handshake kinds the block sends a single PID byte. For one of the two data kinds it sends the PID byte, then passes the payload bytes from the endpoint straight through to the transmit port, then appends the complemented CRC16 of the payload.

The transmit side is a byte-wide valid/ready handshake in the style of a transceiver macrocell. The payload side is also valid/ready. The payload ready signal follows transmit ready, so the block holds no payload storage. The CRC is updated on each payload byte as that byte is accepted. A one-cycle done pulse tells the controller when the last byte of the packet has been taken.

Top module: `usb_pkt_asm`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `tx_valid` and `done` are low and `req_ready` is high.
- R2: The first byte of every packet is the PID byte. It carries the 4-bit PID in bits 3:0 and the bitwise complement of the PID in bits 7:4. The `req_kind` codes map to PIDs as follows: 0 is DATA0 (0011), 1 is DATA1 (1011), 2 is ACK (0010), 3 is NAK (1010), 4 is STALL (1110), 5 is NYET (0110).
- R3: A handshake request (kind 2 to 5) produces exactly one byte on the transmit port, the PID byte, whatever the value of `req_zero`.
- R4: A data request (kind 0 or 1) with `req_zero` low produces the PID byte, then every payload byte in the order the endpoint offered it, up to and including the byte marked `pl_last`, then two CRC bytes.
- R5: The CRC uses polynomial x^16+x^15+x^2+1. The register starts at all ones and takes in each payload byte least significant bit first. The bitwise complement of the final remainder is sent with bits 7:0 first and bits 15:8 second.
- R6: A data request with `req_zero` high takes no payload and sends only the PID byte followed by the two bytes 0x00, 0x00.
- R7: A byte moves on only in a cycle where `tx_valid` and `tx_ready` are both high. While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays the same in the next cycle.
- R8: During the payload, `pl_ready` equals `tx_ready`, `tx_valid` follows `pl_valid`, and `tx_data` carries `pl_data`. A cycle with `pl_valid` low shows `tx_valid` low.
- R9: `done` is high for exactly one cycle. That cycle is the one after the final byte of a packet is transferred. `req_ready` is high only while no packet is in progress, and no byte is offered then.
- R10: A request with `req_kind` 6 or 7 is ignored: no byte is sent, `req_ready` stays high and `done` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Packet request present |
| req_kind | input | 3 | Packet kind code (see R2) |
| req_zero | input | 1 | Data packet has no payload |
| req_ready | output | 1 | Idle; the request is taken on this cycle if valid |
| pl_valid | input | 1 | Payload byte present |
| pl_data | input | 8 | Payload byte |
| pl_last | input | 1 | Current payload byte is the final one |
| pl_ready | output | 1 | Payload byte is taken on this cycle if valid |
| tx_valid | output | 1 | Transmit byte present |
| tx_ready | input | 1 | Transmitter takes the byte on this cycle |
| tx_data | output | 8 | Transmit byte |
| done | output | 1 | One-cycle pulse after the last byte of a packet |

## Verification
The hardest case to reach is a transmitter stall that lands on one of the two CRC bytes, or on the PID byte, while payload bytes are also arriving with gaps. In that case the CRC must stay frozen and the held byte must not change. To get there, the stimulus drives `tx_ready` from a pseudo-random sequence during long data packets and leaves holes in `pl_valid` on every second payload byte. This makes stalls fall on every phase of a packet. Zero-length packets under the same backpressure check the path straight from PID to CRC, where the expected CRC bytes are 0x00, 0x00.

// File: rtl/usbpa_pkg.sv
package usbpa_pkg;

  localparam int BYTE_W = 8;
  localparam int CRC_W  = 16;
  localparam int KIND_W = 3;
  localparam logic [CRC_W-1:0] CRC_SEED = 16'hFFFF;
  // polynomial x^16+x^15+x^2+1 in reflected (LSB-first) form
  localparam logic [CRC_W-1:0] CRC_POLY_LSBF = 16'hA001;

  typedef enum logic [KIND_W-1:0] {
    K_DATA0 = 3'd0,
    K_DATA1 = 3'd1,
    K_ACK   = 3'd2,
    K_NAK   = 3'd3,
    K_STALL = 3'd4,
    K_NYET  = 3'd5
  } pkt_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PID,
    S_BODY,
    S_CRC_LO,
    S_CRC_HI
  } seq_state_e;

  function automatic logic kind_known(input logic [KIND_W-1:0] k);
    return k <= K_NYET;
  endfunction

  function automatic logic kind_is_data(input logic [KIND_W-1:0] k);
    return k <= K_DATA1;
  endfunction

  function automatic logic [3:0] pid_nibble(input logic [KIND_W-1:0] k);
    logic [3:0] n;
    case (k)
      K_DATA0: n = 4'b0011;
      K_DATA1: n = 4'b1011;
      K_ACK:   n = 4'b0010;
      K_NAK:   n = 4'b1010;
      K_STALL: n = 4'b1110;
      default: n = 4'b0110;
    endcase
    return n;
  endfunction

  function automatic logic [BYTE_W-1:0] pid_byte(input logic [3:0] nib);
    return {~nib, nib};
  endfunction

  function automatic logic [CRC_W-1:0] crc16_step(input logic [CRC_W-1:0] crc,
                                                  input logic [BYTE_W-1:0] din);
    logic [CRC_W-1:0] c;
    logic fb;
    c = crc;
    for (int i = 0; i < BYTE_W; i++) begin
      fb = c[0] ^ din[i];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY_LSBF;
    end
    return c;
  endfunction

endpackage

// File: rtl/usbpa_crc16.sv
module usbpa_crc16
  import usbpa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              update,
  input  logic [BYTE_W-1:0] din,
  output logic [CRC_W-1:0]  crc_q
);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) crc_q <= CRC_SEED;
    else if (update)     crc_q <= crc16_step(crc_q, din);
  end

endmodule

// File: rtl/usbpa_seq.sv
module usbpa_seq
  import usbpa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [KIND_W-1:0] req_kind,
  input  logic              req_zero,
  input  logic              pl_valid,
  input  logic              pl_last,
  input  logic              tx_ready,
  output seq_state_e        state_q,
  output logic [BYTE_W-1:0] pid_q,
  output logic              req_ready,
  output logic              tx_valid,
  output logic              byte_fire,
  output logic              crc_clear,
  output logic              crc_update,
  output logic              done_q
);

  logic       data_q;
  logic       zero_q;
  logic       accept;
  logic       pkt_end;
  seq_state_e state_d;

  assign req_ready  = (state_q == S_IDLE);
  assign accept     = req_ready && req_valid && kind_known(req_kind);
  assign byte_fire  = tx_valid && tx_ready;
  assign crc_clear  = accept;
  assign crc_update = (state_q == S_BODY) && byte_fire;
  assign pkt_end    = byte_fire &&
                      ((state_q == S_CRC_HI) || ((state_q == S_PID) && !data_q));

  always_comb begin
    case (state_q)
      S_PID, S_CRC_LO, S_CRC_HI: tx_valid = 1'b1;
      S_BODY:                    tx_valid = pl_valid;
      default:                   tx_valid = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE:   if (accept) state_d = S_PID;
      S_PID:    if (byte_fire) state_d = !data_q ? S_IDLE : (zero_q ? S_CRC_LO : S_BODY);
      S_BODY:   if (byte_fire && pl_last) state_d = S_CRC_LO;
      S_CRC_LO: if (byte_fire) state_d = S_CRC_HI;
      S_CRC_HI: if (byte_fire) state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      pid_q   <= '0;
      data_q  <= 1'b0;
      zero_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= pkt_end;
      if (accept) begin
        pid_q  <= pid_byte(pid_nibble(req_kind));
        data_q <= kind_is_data(req_kind);
        zero_q <= req_zero;
      end
    end
  end

endmodule

// File: rtl/usb_pkt_asm.sv
module usb_pkt_asm
  import usbpa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [KIND_W-1:0] req_kind,
  input  logic              req_zero,
  output logic              req_ready,
  input  logic              pl_valid,
  input  logic [BYTE_W-1:0] pl_data,
  input  logic              pl_last,
  output logic              pl_ready,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  output logic              done
);

  seq_state_e        state_q;
  logic [BYTE_W-1:0] pid_q;
  logic [CRC_W-1:0]  crc_q;
  logic              byte_fire;
  logic              crc_clear;
  logic              crc_update;

  usbpa_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_kind   (req_kind),
    .req_zero   (req_zero),
    .pl_valid   (pl_valid),
    .pl_last    (pl_last),
    .tx_ready   (tx_ready),
    .state_q    (state_q),
    .pid_q      (pid_q),
    .req_ready  (req_ready),
    .tx_valid   (tx_valid),
    .byte_fire  (byte_fire),
    .crc_clear  (crc_clear),
    .crc_update (crc_update),
    .done_q     (done)
  );

  usbpa_crc16 u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (crc_clear),
    .update (crc_update),
    .din    (pl_data),
    .crc_q  (crc_q)
  );

  assign pl_ready = (state_q == S_BODY) && tx_ready;

  always_comb begin
    case (state_q)
      S_PID:    tx_data = pid_q;
      S_BODY:   tx_data = pl_data;
      S_CRC_LO: tx_data = ~crc_q[BYTE_W-1:0];
      S_CRC_HI: tx_data = ~crc_q[CRC_W-1:BYTE_W];
      default:  tx_data = '0;
    endcase
  end

endmodule

// File: rtl/usbpa_chk.sv
module usbpa_chk
  import usbpa_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [KIND_W-1:0] req_kind,
  input logic              req_ready,
  input logic              pl_valid,
  input logic [BYTE_W-1:0] pl_data,
  input logic              pl_ready,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [BYTE_W-1:0] tx_data,
  input logic              done
);

  AST_PID_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && req_kind <= 3'd5) |=> (tx_valid && tx_data[7:4] == ~tx_data[3:0])); // R2

  AST_HOLD_TXDATA: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R7

  AST_PL_FOLLOWS_TX: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready |-> tx_ready); // R8

  AST_PL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_valid && pl_ready) |-> (tx_valid && tx_data == pl_data)); // R8

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !tx_valid); // R9

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_DONE_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(tx_valid && tx_ready)); // R9

  AST_BAD_KIND_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && req_kind > 3'd5) |=> (req_ready && !done)); // R10

endmodule

bind usb_pkt_asm usbpa_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .req_ready (req_ready),
  .pl_valid  (pl_valid),
  .pl_data   (pl_data),
  .pl_ready  (pl_ready),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .done      (done)
);

// File: tb/usb_pkt_asm_bench.sv
module usb_pkt_asm_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_kind = 3'd0;
  logic       req_zero = 1'b0;
  logic       req_ready;
  logic       pl_valid = 1'b0;
  logic [7:0] pl_data = 8'h00;
  logic       pl_last = 1'b0;
  logic       pl_ready;
  logic       tx_valid;
  logic       tx_ready = 1'b1;
  logic [7:0] tx_data;
  logic       done;

  int total = 0;
  int bad = 0;
  bit bp_on = 1'b0;
  logic [15:0] lfsr = 16'h5A3C;
  logic [7:0] pay [64];
  logic [7:0] exp_q [$];
  string      tag_q [$];
  bit         stalled = 1'b0;
  logic [7:0] held;

  always #4 clk = ~clk;

  usb_pkt_asm u_usb_pkt_asm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_zero(req_zero), .req_ready(req_ready), .pl_valid(pl_valid),
    .pl_data(pl_data), .pl_last(pl_last), .pl_ready(pl_ready),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [3:0] ref_pid(input logic [2:0] k);
    logic [3:0] t [6];
    t[0] = 4'h3; t[1] = 4'hB; t[2] = 4'h2; t[3] = 4'hA; t[4] = 4'hE; t[5] = 4'h6;
    return t[k];
  endfunction

  // MSB-first form on bit-reversed input, reversed at the end
  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] r, o;
    logic top;
    r = 16'hFFFF;
    for (int k = 0; k < n; k++)
      for (int b = 0; b < 8; b++) begin
        top = r[15] ^ pay[k][b];
        r = {r[14:0], 1'b0};
        if (top) r = r ^ 16'h8005;
      end
    for (int b = 0; b < 16; b++) o[b] = r[15-b];
    return ~o;
  endfunction

  // backpressure source
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready = bp_on ? (lfsr[0] | lfsr[5]) : 1'b1;
  end

  // monitor: compare transferred bytes against the scoreboard, watch holds
  always @(negedge clk) begin
    if (rst_n) begin
      if (stalled) chk(tx_valid && tx_data == held, "R7 hold", {23'd0, tx_valid, tx_data}, {24'd1, held});
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R7 unexpected byte", tx_data, 0);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(tx_data == e, t, tx_data, e);
        end
      end
      stalled = tx_valid && !tx_ready;
      held = tx_data;
    end
  end

  task automatic send_pkt(input logic [2:0] kind, input int n, input logic [7:0] seed,
                          input bit zero, input bit gaps);
    bit is_data;
    logic [15:0] c;
    bit got;
    is_data = (kind <= 3'd1);
    for (int i = 0; i < n; i++) pay[i] = seed + 8'(i * 37);
    exp_q.push_back({~ref_pid(kind), ref_pid(kind)}); tag_q.push_back("R2 pid");
    if (is_data) begin
      if (!zero) for (int i = 0; i < n; i++) begin exp_q.push_back(pay[i]); tag_q.push_back("R4 payload"); end
      c = zero ? ref_crc(0) : ref_crc(n);
      exp_q.push_back(c[7:0]);  tag_q.push_back(zero ? "R6 crc lo" : "R5 crc lo");
      exp_q.push_back(c[15:8]); tag_q.push_back(zero ? "R6 crc hi" : "R5 crc hi");
    end
    @(posedge clk); #1;
    req_valid = 1'b1; req_kind = kind; req_zero = zero;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (is_data && !zero)
      for (int i = 0; i < n; i++) begin
        if (gaps && (i % 2 == 1)) begin
          @(negedge clk);
          chk(!tx_valid, "R8 gap", tx_valid, 0);
          @(posedge clk); #1;
        end
        pl_valid = 1'b1; pl_data = pay[i]; pl_last = (i == n - 1);
        do @(negedge clk); while (!pl_ready);
        @(posedge clk); #1;
        pl_valid = 1'b0; pl_last = 1'b0;
      end
    got = 1'b0;
    for (int w = 0; w < 400 && !got; w++) begin
      @(negedge clk);
      if (done) got = 1'b1;
    end
    chk(got, is_data ? "R9 done" : "R3 done", got, 1);
    chk(exp_q.size() == 0, is_data ? "R4 all bytes" : "R3 single byte", exp_q.size(), 0);
  endtask

  task automatic bad_kind(input logic [2:0] kind);
    @(posedge clk); #1;
    req_valid = 1'b1; req_kind = kind;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(req_ready && !tx_valid && !done, "R10 ignored", {req_ready, tx_valid, done}, 3'b100);
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R9 actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!tx_valid && !done && req_ready, "R1 in reset", {tx_valid, done, req_ready}, 3'b001);
    @(posedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!tx_valid && !done && req_ready, "R1 after reset", {tx_valid, done, req_ready}, 3'b001);
    // handshakes, no stall, then under stall; req_zero has no effect
    for (int k = 2; k <= 5; k++) send_pkt(3'(k), 0, 8'h00, 1'b0, 1'b0);
    bp_on = 1'b1;
    for (int k = 2; k <= 5; k++) send_pkt(3'(k), 0, 8'h00, 1'b1, 1'b0);
    bp_on = 1'b0;
    send_pkt(3'd0, 1, 8'h00, 1'b0, 1'b0);
    send_pkt(3'd1, 4, 8'h00, 1'b0, 1'b0);
    send_pkt(3'd0, 0, 8'h00, 1'b1, 1'b0);   // R6
    bad_kind(3'd6);
    bad_kind(3'd7);
    bp_on = 1'b1;
    send_pkt(3'd1, 5, 8'hC3, 1'b0, 1'b1);
    send_pkt(3'd0, 20, 8'h11, 1'b0, 1'b1);
    send_pkt(3'd1, 0, 8'h00, 1'b1, 1'b0);   // R6 under stall
    send_pkt(3'd0, 33, 8'hFE, 1'b0, 1'b0);
    bad_kind(3'd7);
    send_pkt(3'd4, 0, 8'h00, 1'b0, 1'b0);
    bp_on = 1'b0;
    repeat (4) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule